// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block receives control words for a frequency synthesizer over three wires: a serial data line, a shift clock and a latch strobe. It runs on the chip's system clock. All three wires are brought into that domain through synchronizers, and edges are found there. Each rising edge of the shift clock pushes one data bit into a 24-bit staging word, most significant bit first.

A rising edge of the latch strobe commits the staging word. Its two least significant bits, which are the last two shifted in, pick one of four destination registers. The upper 22 bits are copied into that register. The other three registers keep their values.

The destination registers drive the synthesizer directly. Besides the raw registers, the block brings out several decoded fields: the reference divide ratio, the two feedback counter values, the prescaler select, the two power-down bits, and the combined synchronous power-down request. The loader never gates itself. Writes are accepted at any time, including while the synthesizer is powered down.

Top module: `serprog_regif`

## Requirements
- R1: After reset, all four destination registers and every decoded output read zero.
- R2: Bits are taken on each rising edge of the shift clock, most significant first, into a 24-bit staging word. On a commit, the first bit of a full 24-bit word becomes bit 21 of the payload.
- R3: The last two bits shifted in form the address: 0 selects the reference register, 1 function register 1, 2 function register 2 and 3 the feedback register. Only the addressed register changes on a commit.
- R4: A commit happens only on a rising edge of the latch strobe. Holding the strobe high while more bits are shifted commits nothing. The next rising edge commits the word shifted in meanwhile.
- R5: When the strobe rises after fewer than 24 new bits, the staging word as it stands is committed. That word holds the older bits shifted up by the number of new bits.
- R6: The reference ratio output equals bits 14:0 of the reference register. Both 3 and 32767 are stored unchanged.
- R7: The feedback counter A output is bits 4:0 of the feedback register. Counter B is bits 14:5. The power-down request is bit 20.
- R8: The prescaler select output is bit 0 of function register 1. The power-down mode output is bit 19 of function register 2.
- R9: The synchronous power-down output is high only when both the power-down mode bit and the power-down request bit are set.
- R10: Words are shifted and committed normally while the synchronous power-down output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock |
| serLatch | input | 1 | Latch strobe; rising edge commits |
| refReg | output | 22 | Reference register contents |
| func1Reg | output | 22 | Function register 1 contents |
| func2Reg | output | 22 | Function register 2 contents |
| fbReg | output | 22 | Feedback register contents |
| refRatio | output | 15 | Reference divide ratio |
| fbCountA | output | 5 | Feedback counter A value |
| fbCountB | output | 10 | Feedback counter B value |
| prescSel | output | 1 | Prescaler modulus select |
| pwrDownMode | output | 1 | Power-down mode bit |
| pwrDownReq | output | 1 | Power-down request bit |
| syncPowerDown | output | 1 | Combined synchronous power-down |

## Verification
The serial signals pass through two synchronizer flops and an edge register. A commit therefore reaches the destination registers on the third system-clock edge after the latch strobe is first sampled high. Bits reach the staging word with the same delay. The driver holds every serial level for at least three clock cycles. It queues the expected outcome after the strobe has been high for four cycles. The monitor then waits three more falling edges before it compares, so every result is already settled when it is sampled and the next serial activity has not yet started.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  parameter int WORD_W   = 24;
  parameter int ADDR_W   = 2;
  parameter int PAY_W    = WORD_W - ADDR_W;
  parameter int NUM_DEST = 1 << ADDR_W;
  parameter int SYNC_STAGES = 2;

  // destination indices (address codes)
  parameter int DEST_REF = 0;
  parameter int DEST_F1  = 1;
  parameter int DEST_F2  = 2;
  parameter int DEST_FB  = 3;

  // field positions inside the payloads
  parameter int REF_RATIO_W  = 15;
  parameter int FB_A_LSB     = 0;
  parameter int FB_A_W       = 5;
  parameter int FB_B_LSB     = 5;
  parameter int FB_B_W       = 10;
  parameter int FB_PD_BIT    = 20;
  parameter int F1_PRESC_BIT = 0;
  parameter int F2_PDMODE_BIT = 19;

  typedef struct packed {
    logic shift;
    logic commit;
  } ctrlStrobe_t;
endpackage

// File: rtl/serprog_ctrl.sv
module serprog_ctrl
  import serprog_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serData,
  input  logic        serClk,
  input  logic        serLatch,
  output ctrlStrobe_t strobe,
  output logic        bitOut
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] dataSync, clkSync, latchSync;
  logic clkPrev, latchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSync  <= '0;
      clkSync   <= '0;
      latchSync <= '0;
      clkPrev   <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      if (STAGES > 1) begin
        dataSync  <= {dataSync[TOP-1:0], serData};
        clkSync   <= {clkSync[TOP-1:0], serClk};
        latchSync <= {latchSync[TOP-1:0], serLatch};
      end else begin
        dataSync[0]  <= serData;
        clkSync[0]   <= serClk;
        latchSync[0] <= serLatch;
      end
      clkPrev   <= clkSync[TOP];
      latchPrev <= latchSync[TOP];
    end
  end

  always_comb begin
    strobe.shift  = clkSync[TOP] & ~clkPrev;
    strobe.commit = latchSync[TOP] & ~latchPrev;
    bitOut        = dataSync[TOP];
  end

  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.commit) else $error("commit held"); // R4
  AST_SHIFT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> !strobe.shift) else $error("shift held"); // R2
endmodule

// File: rtl/serprog_datapath.sv
module serprog_datapath
  import serprog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        bitIn,
  output logic [NUM_DEST-1:0][PAY_W-1:0] destReg
);
  logic [WORD_W-1:0]   stageWord;
  logic [ADDR_W-1:0]   addrField;
  logic [PAY_W-1:0]    payField;
  logic [NUM_DEST-1:0] wrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageWord <= '0;
    else if (strobe.shift) stageWord <= {stageWord[WORD_W-2:0], bitIn};
  end

  assign addrField = stageWord[ADDR_W-1:0];
  assign payField  = stageWord[WORD_W-1:ADDR_W];

  for (genvar d = 0; d < NUM_DEST; d++) begin : gDest
    assign wrEn[d] = strobe.commit && (addrField == ADDR_W'(d));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) destReg[d] <= '0;
      else if (wrEn[d]) destReg[d] <= payField;
    end
  end

  AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrEn)) else $error("multiple destinations"); // R3
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(destReg)) else $error("register moved"); // R4
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shift |=> stageWord[WORD_W-1:1] == $past(stageWord[WORD_W-2:0]))
    else $error("shift order"); // R2
endmodule

// File: rtl/serprog_regif.sv
module serprog_regif
  import serprog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serData,
  input  logic        serClk,
  input  logic        serLatch,
  output logic [21:0] refReg,
  output logic [21:0] func1Reg,
  output logic [21:0] func2Reg,
  output logic [21:0] fbReg,
  output logic [14:0] refRatio,
  output logic [4:0]  fbCountA,
  output logic [9:0]  fbCountB,
  output logic        prescSel,
  output logic        pwrDownMode,
  output logic        pwrDownReq,
  output logic        syncPowerDown
);
  ctrlStrobe_t strobe;
  logic        sampledBit;
  logic [NUM_DEST-1:0][PAY_W-1:0] destReg;

  serprog_ctrl #(.STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .strobe(strobe), .bitOut(sampledBit)
  );

  serprog_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIn(sampledBit),
    .destReg(destReg)
  );

  always_comb begin
    refReg        = destReg[DEST_REF];
    func1Reg      = destReg[DEST_F1];
    func2Reg      = destReg[DEST_F2];
    fbReg         = destReg[DEST_FB];
    refRatio      = refReg[REF_RATIO_W-1:0];
    fbCountA      = fbReg[FB_A_LSB +: FB_A_W];
    fbCountB      = fbReg[FB_B_LSB +: FB_B_W];
    prescSel      = func1Reg[F1_PRESC_BIT];
    pwrDownMode   = func2Reg[F2_PDMODE_BIT];
    pwrDownReq    = fbReg[FB_PD_BIT];
    syncPowerDown = pwrDownMode & pwrDownReq;
  end

  AST_PD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    syncPowerDown |-> func2Reg[F2_PDMODE_BIT] && fbReg[FB_PD_BIT])
    else $error("power-down without both bits"); // R9
endmodule

// File: tb/serprog_regif_test.sv
module serprog_regif_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, serLatch = 1'b0;
  logic [21:0] refReg, func1Reg, func2Reg, fbReg;
  logic [14:0] refRatio;
  logic [4:0]  fbCountA;
  logic [9:0]  fbCountB;
  logic prescSel, pwrDownMode, pwrDownReq, syncPowerDown;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          commit;
    logic [23:0] word;
    string       tag;
  } item_t;
  item_t expQ[$];
  event evItem;

  logic [23:0] modelShift = '0;
  logic [21:0] model [4];

  always #4 clk = ~clk;

  serprog_regif uut (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .serLatch(serLatch), .refReg(refReg), .func1Reg(func1Reg),
    .func2Reg(func2Reg), .fbReg(fbReg), .refRatio(refRatio),
    .fbCountA(fbCountA), .fbCountB(fbCountB), .prescSel(prescSel),
    .pwrDownMode(pwrDownMode), .pwrDownReq(pwrDownReq),
    .syncPowerDown(syncPowerDown)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    repeat (3) @(negedge clk);
    serClk = 1'b1;
    modelShift = {modelShift[22:0], b};
    repeat (4) @(negedge clk);
    serClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendBits(input logic [23:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i]);
  endtask

  task automatic pushItem(input bit c, input string tag);
    item_t it;
    it.commit = c;
    it.word   = modelShift;
    it.tag    = tag;
    expQ.push_back(it);
    -> evItem;
  endtask

  task automatic latchUp(input string tag);
    serLatch = 1'b1;
    repeat (4) @(negedge clk);
    pushItem(1'b1, tag);
    repeat (6) @(negedge clk);
  endtask

  task automatic latchDown();
    serLatch = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic writeWord(input logic [1:0] addr, input logic [21:0] pay, input string tag);
    sendBits({pay, addr}, 24);
    latchUp(tag);
    latchDown();
  endtask

  // monitor: pops expected items and compares once results are settled
  initial begin
    forever begin
      @(evItem);
      repeat (3) @(negedge clk);
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        if (it.commit) model[it.word[1:0]] = it.word[23:2];
        chk({it.tag, " refReg"},   {10'd0, refReg},   {10'd0, model[0]});
        chk({it.tag, " func1Reg"}, {10'd0, func1Reg}, {10'd0, model[1]});
        chk({it.tag, " func2Reg"}, {10'd0, func2Reg}, {10'd0, model[2]});
        chk({it.tag, " fbReg"},    {10'd0, fbReg},    {10'd0, model[3]});
        chk("R6 refRatio", {17'd0, refRatio}, {17'd0, model[0][14:0]});
        chk("R7 fbCountA", {27'd0, fbCountA}, {27'd0, model[3][4:0]});
        chk("R7 fbCountB", {22'd0, fbCountB}, {22'd0, model[3][14:5]});
        chk("R7 pwrDownReq", {31'd0, pwrDownReq}, {31'd0, model[3][20]});
        chk("R8 prescSel", {31'd0, prescSel}, {31'd0, model[1][0]});
        chk("R8 pwrDownMode", {31'd0, pwrDownMode}, {31'd0, model[2][19]});
        chk("R9 syncPowerDown", {31'd0, syncPowerDown},
            {31'd0, model[2][19] & model[3][20]});
      end
    end
  end

  // driver
  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 refReg reset", {10'd0, refReg}, 32'd0);
    chk("R1 fbReg reset", {10'd0, fbReg}, 32'd0);
    chk("R1 syncPowerDown reset", {31'd0, syncPowerDown}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 func1Reg after release", {10'd0, func1Reg}, 32'd0);
    chk("R1 func2Reg after release", {10'd0, func2Reg}, 32'd0);

    writeWord(2'd0, 22'd3, "R3 R6 ref=3");
    writeWord(2'd1, 22'h2A5A5B, "R2 R8 f1 pattern");
    writeWord(2'd3, {1'b0, 1'b1, 5'd0, 10'h3FF, 5'd5}, "R7 fb pd only");
    writeWord(2'd2, 22'h080000, "R9 f2 pd mode");
    chk("R9 both bits set", {31'd0, syncPowerDown}, 32'd1);
    writeWord(2'd0, 22'h007FFF, "R10 R6 ref=32767 in power-down");
    writeWord(2'd3, 22'h3FFFFF, "R10 fb all ones in power-down");

    // latch held high: shifting a new word must not commit
    sendBits({22'h155555, 2'd1}, 24);
    latchUp("R4 first rise");
    sendBits({22'h0ABCDE, 2'd2}, 24);
    pushItem(1'b0, "R4 shifted while high");
    repeat (4) @(negedge clk);
    latchDown();
    pushItem(1'b0, "R4 after fall");
    repeat (8) @(negedge clk);
    latchUp("R4 second rise");
    latchDown();

    // short write: only 8 new bits
    sendBits(24'h0000C0, 8);
    latchUp("R5 eight bits");
    latchDown();
    sendBits(24'h000003, 3);
    latchUp("R5 three bits");
    latchDown();

    writeWord(2'd2, 22'h000000, "R9 mode cleared");
    writeWord(2'd0, 22'h200001, "R2 R3 msb first");

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule